// File: doc/BRIEF.md
# SPI Flash Controller, User-Mode Byte Path

This block is a memory-mapped SPI master for serial flash devices on two chip selects. A host drives it through a small 32-bit bus that has two kinds of access: register accesses, which reach a configuration register and one control register per chip select, and data-window accesses, which move single bytes to or from a chosen chip select. The block supports only single-bit SPI mode 0. SCK idles low, MOSI changes after a falling edge and MISO is sampled on the rising edge.

Software starts a frame by writing the user-mode code into a chip select's control register. That chip select goes low and stays low until software writes a different mode code, so one frame can carry any number of bytes. A write to the window sends one byte. A read from the window sends 0xFF and returns the byte captured from MISO. One shift engine serves both chip selects. Per chip select, a 4-bit divider code sets the SCK rate and one bit selects the bit order.

The bus uses a valid/ready handshake. The host raises `bus_valid` with a stable payload and holds it until `bus_ready` is high at a rising clock edge; the access completes at that edge. `bus_ready` is combinational and may be low for many cycles. Reads return `bus_rdata` in the same cycle as the handshake.

Top module: `spi_user_ctrl`

## Requirements
- R1: Register map on `bus_addr` with `bus_win`=0:
  - 0x00 holds write-enable bits at bit 16 (CS0) and bit 17 (CS1).
  - 0x10 (CS0) and 0x14 (CS1) hold the control fields: mode [1:0], LSB-first bit 5 and divider code [11:8].
  - All other bits read zero. Bit 4 (clock polarity) is not stored and has no effect on SCK.
  - When no shift is in progress, a register access completes in the cycle it is presented.
- R2: `spi_cs_n[i]` is low exactly while chip select i's mode field holds 3 (user mode). It follows a register write within two clock cycles. Modes 0, 1 and 2 leave it high.
- R3: A window write (`bus_win`=1) to a chip select in user mode with its write-enable set sends `bus_wdata[7:0]` with exactly 8 rising SCK edges. With bit 5 clear the order is MSB first. MOSI never changes while SCK is high, and SCK is low whenever no shift is in progress. The write itself completes at once when the engine is idle.
- R4: With bit 5 set, bits leave LSB first, and the first bit sampled on a read lands in bit 0 of the result.
- R5: A window read in user mode sends 0xFF and returns the 8 sampled MISO bits in `bus_rdata[7:0]`, with the upper bits zero. With bit 5 clear, the first sampled bit is bit 7. `bus_ready` stays low until all 8 bits are sampled: 8·P+L+1 cycles after the read is presented to an idle engine.
- R6: The divider code c sets the SCK period P in bus clocks:
  - For c ≥ 8, P = 2·(15−c)+1.
  - For c ≤ 7, P = 2·(8−c).
  - Code 15 (divide-by-1) runs at P=2.
  - Each high phase lasts H=⌊P/2⌋ cycles and each low phase L=⌈P/2⌉ cycles.
- R7: A window write to a chip select whose write-enable bit is clear completes at once and produces no SCK activity.
- R8: A window access to a chip select whose mode is not 3 completes at once. A write is dropped with no SCK activity, and a read returns zero.
- R9: While a byte is shifting, every register access and every user-mode window access that would shift holds `bus_ready` low. The wait ends exactly 8·P+L cycles after the shifting write was accepted.
- R10: At least L cycles pass from a chip select falling to the first SCK rise. At least L cycles pass from the last SCK fall until the block accepts the register write that can raise the chip select. A chip select never changes while a byte is shifting.
- R11: Reset clears all registers, drives both chip selects high and holds SCK low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request; held with stable payload until `bus_ready` |
| bus_ready | output | 1 | Access completes at the rising edge where valid and ready are both high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 1 = data-window access, 0 = register access |
| bus_cs_sel | input | 1 | Chip select whose data window is addressed |
| bus_addr | input | 8 | Register byte offset (ignored for window accesses) |
| bus_wdata | input | 32 | Write data; window writes use bits [7:0] |
| bus_rdata | output | 32 | Read data, valid at the handshake |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 2 | Active-low chip selects |

## Verification
Every divider code is tried with both bit orders. Each combination writes one byte and reads one byte, and the data is chosen so that a reversed byte differs from the original. This separates the even-divisor codes from the odd ones, tells the two bit orders apart on both MOSI and MISO, and shows any wrong high or low phase length or a missing tail phase through the measured stall lengths. Separate patterns cover the rest:
- A second chip select is used on its own.
- A write is sent with its write-enable bit cleared.
- Accesses are made in a non-user mode.
- Two writes are sent back to back.

These tell a correctly dropped access apart from one that leaks onto SCK or waits for the engine.

// File: rtl/spi_uc_pkg.sv
package spi_uc_pkg;

  localparam logic [1:0] MODE_USER = 2'd3;

  typedef enum logic [1:0] {ENG_IDLE, ENG_LOW, ENG_HIGH, ENG_TAIL} eng_st_t;
  typedef enum logic [1:0] {RD_NONE, RD_WAIT, RD_HAVE} rd_st_t;

  // SCK period in bus clocks for a 4-bit divider code; divide-by-1 runs at 2
  function automatic int unsigned div_period(input logic [3:0] code);
    int unsigned p;
    if (code[3]) p = 2 * (7 - int'(code[2:0])) + 1;
    else         p = 2 * (8 - int'(code[2:0]));
    if (p < 2) p = 2;
    return p;
  endfunction

endpackage

// File: rtl/spi_uc_regs.sv
module spi_uc_regs #(
  parameter int NUM_CS = 2,
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int DIVW   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [AW-1:0]                  addr,
  input  logic [DW-1:0]                  wdata,
  output logic [DW-1:0]                  rdata,
  output logic [NUM_CS-1:0][1:0]         mode_o,
  output logic [NUM_CS-1:0]              lsb_o,
  output logic [NUM_CS-1:0][DIVW-1:0]    div_o,
  output logic [NUM_CS-1:0]              wen_o
);
  localparam logic [AW-1:0] CFG_ADDR = '0;
  localparam int CTRL_BASE = 16;
  localparam int WEN_LSB   = 16;
  localparam int LSB_BIT   = 5;
  localparam int DIV_LSB   = 8;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    localparam logic [AW-1:0] CTRL_ADDR = AW'(CTRL_BASE + 4 * i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wen_o[i]  <= 1'b0;
        mode_o[i] <= 2'd0;
        lsb_o[i]  <= 1'b0;
        div_o[i]  <= '0;
      end else if (wr_en) begin
        if (addr == CFG_ADDR) wen_o[i] <= wdata[WEN_LSB + i];
        if (addr == CTRL_ADDR) begin
          mode_o[i] <= wdata[1:0];
          lsb_o[i]  <= wdata[LSB_BIT];
          div_o[i]  <= wdata[DIV_LSB +: DIVW];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (addr == CFG_ADDR) rdata[WEN_LSB + i] = wen_o[i];
      if (addr == AW'(CTRL_BASE + 4 * i)) begin
        rdata[1:0]              = mode_o[i];
        rdata[LSB_BIT]          = lsb_o[i];
        rdata[DIV_LSB +: DIVW]  = div_o[i];
      end
    end
  end

endmodule

// File: rtl/spi_uc_shifter.sv
module spi_uc_shifter #(
  parameter int W    = 8,
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [W-1:0]    tx_byte,
  input  logic            lsb_first,
  input  logic [DIVW-1:0] div_code,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic [W-1:0]    rx_byte,
  output logic            sck,
  output logic            mosi
);
  import spi_uc_pkg::*;

  localparam int CNT_W = DIVW + 1;
  localparam int BIT_W = (W > 1) ? $clog2(W) : 1;

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = v[W-1-k];
    return r;
  endfunction

  eng_st_t            st;
  logic [CNT_W-1:0]   cnt, lo_len, hi_len, per, lo_new;
  logic [BIT_W-1:0]   bitn;
  logic [W-1:0]       sh, rx, tx_ord;
  logic               lsb_q;

  assign per    = CNT_W'(div_period(div_code));
  assign lo_new = (per + CNT_W'(1)) >> 1;
  assign tx_ord = lsb_first ? rev(tx_byte) : tx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ENG_IDLE; cnt <= '0; lo_len <= '0; hi_len <= '0; bitn <= '0;
      sh <= '0; rx <= '0; lsb_q <= 1'b0; sck <= 1'b0; mosi <= 1'b0;
    end else begin
      case (st)
        ENG_IDLE: if (start) begin
          lsb_q  <= lsb_first;
          lo_len <= lo_new;
          hi_len <= per >> 1;
          cnt    <= lo_new - CNT_W'(1);
          sh     <= tx_ord;
          mosi   <= tx_ord[W-1];
          bitn   <= '0;
          st     <= ENG_LOW;
        end
        ENG_LOW: if (cnt == '0) begin
          sck <= 1'b1;
          rx  <= {rx[W-2:0], miso};
          cnt <= hi_len - CNT_W'(1);
          st  <= ENG_HIGH;
        end else cnt <= cnt - CNT_W'(1);
        ENG_HIGH: if (cnt == '0) begin
          sck <= 1'b0;
          cnt <= lo_len - CNT_W'(1);
          if (bitn == BIT_W'(W - 1)) st <= ENG_TAIL;
          else begin
            bitn <= bitn + BIT_W'(1);
            sh   <= sh << 1;
            mosi <= sh[W-2];
            st   <= ENG_LOW;
          end
        end else cnt <= cnt - CNT_W'(1);
        default: if (cnt == '0) st <= ENG_IDLE;
                 else cnt <= cnt - CNT_W'(1);
      endcase
    end
  end

  assign busy    = (st != ENG_IDLE);
  assign done    = (st == ENG_TAIL) && (cnt == '0);
  assign rx_byte = lsb_q ? rev(rx) : rx;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);                                                 // R3
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));                                          // R3
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);                                                // R9

endmodule

// File: rtl/spi_user_ctrl.sv
module spi_user_ctrl #(
  parameter int NUM_CS = 2,
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int BYTE_W = 8,
  parameter int DIVW   = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic              bus_win,
  input  logic [CS_W-1:0]   bus_cs_sel,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  import spi_uc_pkg::*;

  logic [NUM_CS-1:0][1:0]      mode;
  logic [NUM_CS-1:0]           lsb, wen;
  logic [NUM_CS-1:0][DIVW-1:0] div;
  logic [DW-1:0]               reg_rdata;
  logic                        reg_wr, start, eng_busy, eng_done, user, busy_all;
  logic [BYTE_W-1:0]           tx, rx_byte, rx_q;
  rd_st_t                      rd_st;

  spi_uc_regs #(.NUM_CS(NUM_CS), .AW(AW), .DW(DW), .DIVW(DIVW)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(reg_rdata), .mode_o(mode), .lsb_o(lsb), .div_o(div), .wen_o(wen));

  spi_uc_shifter #(.W(BYTE_W), .DIVW(DIVW)) i_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx),
    .lsb_first(lsb[bus_cs_sel]), .div_code(div[bus_cs_sel]), .miso(spi_miso),
    .busy(eng_busy), .done(eng_done), .rx_byte(rx_byte),
    .sck(spi_sck), .mosi(spi_mosi));

  assign user     = (mode[bus_cs_sel] == MODE_USER);
  assign busy_all = eng_busy || (rd_st == RD_WAIT);

  always_comb begin
    bus_ready = 1'b0;
    bus_rdata = '0;
    reg_wr    = 1'b0;
    start     = 1'b0;
    tx        = bus_wdata[BYTE_W-1:0];
    if (bus_valid) begin
      if (!bus_win) begin
        bus_ready = !busy_all;
        bus_rdata = reg_rdata;
        reg_wr    = bus_write && !busy_all;
      end else if (!user) begin
        bus_ready = 1'b1;
      end else if (bus_write) begin
        bus_ready = !wen[bus_cs_sel] || !busy_all;
        start     = wen[bus_cs_sel] && !busy_all;
      end else if (rd_st == RD_HAVE) begin
        bus_ready = 1'b1;
        bus_rdata = DW'(rx_q);
      end else begin
        start = !busy_all;
        tx    = '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_st <= RD_NONE;
      rx_q  <= '0;
    end else begin
      case (rd_st)
        RD_NONE: if (start && !bus_write) rd_st <= RD_WAIT;
        RD_WAIT: if (eng_done) begin rd_st <= RD_HAVE; rx_q <= rx_byte; end
        default: if (bus_valid && bus_ready) rd_st <= RD_NONE;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csn
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) spi_cs_n[i] <= 1'b1;
      else        spi_cs_n[i] <= (mode[i] != MODE_USER);
    end
  end

  AST_CS_HELD_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> $stable(spi_cs_n));                                 // R10
  AST_READ_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_win && !bus_write && user) |-> (rd_st == RD_HAVE)); // R5
  AST_DROP_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_win && !user) |=> !spi_sck || $past(eng_busy)); // R8

endmodule

// File: tb/test_spi_user_ctrl.sv
module test_spi_user_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_win = 1'b0;
  logic [0:0]  bus_cs_sel = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_miso;
  logic [1:0]  spi_cs_n;

  int errors = 0, checks = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  spi_user_ctrl i_spi_user_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_win(bus_win), .bus_cs_sel(bus_cs_sel),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  // flash model: captures MOSI on rise, presents MSB-first byte on MISO
  logic [7:0] s_rx = '0, s_tx = '0;
  int falls = 0;
  always @(posedge spi_sck) s_rx = {s_rx[6:0], spi_mosi};
  always @(negedge spi_sck) falls++;
  assign spi_miso = s_tx[7 - (falls % 8)];

  // SCK phase monitor
  int exp_h = 1, exp_l = 1, run = 0, rises = 0, bad_hi = 0, bad_lo = 0;
  logic prev_sck = 1'b0;
  always @(negedge clk) begin
    if (spi_sck !== prev_sck) begin
      if (prev_sck) begin
        if (run != exp_h) bad_hi++;
      end else begin
        if ((rises % 8) != 0 && run != exp_l) bad_lo++;
        rises++;
      end
      run = 1;
    end else run++;
    prev_sck = spi_sck;
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = v[7-k];
    return r;
  endfunction

  function automatic int per_of(input int c);
    int p;
    p = (c >= 8) ? 2 * (15 - c) + 1 : 2 * (8 - c);
    return (p < 2) ? 2 : p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input bit win, input bit wr, input bit sel, input logic [7:0] addr,
                     input logic [31:0] wd, output logic [31:0] rd, output int wt);
    @(negedge clk);
    bus_valid = 1'b1; bus_win = win; bus_write = wr; bus_cs_sel = sel;
    bus_addr = addr; bus_wdata = wd; wt = 0;
    #1;
    while (!bus_ready && wt < 5000) begin
      wt++;
      @(negedge clk);
      #1;
    end
    rd = bus_rdata;
    @(posedge clk);
    #1 bus_valid = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input int code, input bit lsb, input logic [1:0] m);
    return {20'b0, 4'(code), 2'b00, lsb, 1'b1, 2'b00, m};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int wt, r0, bh, bl, p, l;
    logic [7:0] b, pat;
    repeat (3) @(negedge clk);
    #1;
    chk(spi_cs_n == 2'b11, "R11 cs_n reset", int'(spi_cs_n), 3);
    chk(spi_sck == 1'b0, "R11 sck reset", int'(spi_sck), 0);
    rst_n = 1'b1;
    bus(0, 0, 0, 8'h00, 0, rd, wt); chk(rd == 0, "R11 cfg reset", rd, 0);
    bus(0, 0, 0, 8'h10, 0, rd, wt); chk(rd == 0, "R11 ctrl0 reset", rd, 0);
    bus(0, 0, 0, 8'h14, 0, rd, wt); chk(rd == 0, "R11 ctrl1 reset", rd, 0);
    chk(wt == 0, "R1 register access immediate", wt, 0);

    // R1 field readback, R2 chip select follows mode
    bus(0, 1, 0, 8'h00, 32'hFFFF_FFFF, rd, wt);
    bus(0, 0, 0, 8'h00, 0, rd, wt); chk(rd == 32'h0003_0000, "R1 cfg readback", rd, 32'h0003_0000);
    bus(0, 1, 0, 8'h10, 32'hFFFF_FFFF, rd, wt);
    bus(0, 0, 0, 8'h10, 0, rd, wt); chk(rd == 32'h0000_0F23, "R1 ctrl0 readback", rd, 32'hF23);
    repeat (2) @(negedge clk);
    chk(spi_cs_n == 2'b10, "R2 cs0 low in user mode", int'(spi_cs_n), 2);
    chk(spi_sck == 1'b0, "R1 polarity bit has no effect", int'(spi_sck), 0);
    for (int m = 0; m < 3; m++) begin
      bus(0, 1, 0, 8'h10, ctrl(0, 0, 2'(m)), rd, wt);
      repeat (2) @(negedge clk);
      chk(spi_cs_n == 2'b11, "R2 cs0 high in non-user mode", int'(spi_cs_n), 3);
    end

    // sweep every divider code and both bit orders on CS0
    for (int code = 0; code < 16; code++) begin
      for (int lsb = 0; lsb < 2; lsb++) begin
        p = per_of(code); l = (p + 1) / 2;
        exp_h = p / 2; exp_l = l;
        bus(0, 1, 0, 8'h10, ctrl(code, lsb[0], 2'd3), rd, wt);
        repeat (2) @(negedge clk);
        chk(spi_cs_n == 2'b10, "R2 cs0 asserted", int'(spi_cs_n), 2);
        r0 = rises; bh = bad_hi; bl = bad_lo;
        b = 8'((code * 37 + lsb * 91 + 5) ^ 8'h1C);
        bus(1, 1, 0, 0, {24'b0, b}, rd, wt);
        chk(wt == 0, "R3 write accepted at once", wt, 0);
        bus(0, 0, 0, 8'h00, 0, rd, wt);
        chk(wt == 8 * p + l, "R9 R10 stall until byte done", wt, 8 * p + l);
        chk(s_rx == (lsb ? rev8(b) : b), lsb ? "R4 lsb-first write" : "R3 msb-first write",
            s_rx, lsb ? rev8(b) : b);
        chk(rises - r0 == 8, "R3 eight clocks", rises - r0, 8);
        chk(bad_hi == bh && bad_lo == bl, "R6 phase lengths", bad_hi - bh + bad_lo - bl, 0);
        pat = 8'((code * 53 + lsb * 29 + 3) ^ 8'hA6);
        s_tx = pat;
        bus(1, 0, 0, 0, 0, rd, wt);
        chk(rd == {24'b0, (lsb ? rev8(pat) : pat)}, lsb ? "R4 lsb-first read" : "R5 read data",
            rd, lsb ? rev8(pat) : pat);
        chk(wt == 8 * p + l + 1, "R5 ready after last sample", wt, 8 * p + l + 1);
        chk(s_rx == 8'hFF, "R5 read sends 0xFF", s_rx, 8'hFF);
      end
    end
    bus(0, 1, 0, 8'h10, ctrl(0, 0, 2'd0), rd, wt);

    // CS1 on its own
    exp_h = 1; exp_l = 1;
    bus(0, 1, 0, 8'h14, ctrl(7, 0, 2'd3), rd, wt);
    repeat (2) @(negedge clk);
    chk(spi_cs_n == 2'b01, "R2 cs1 only", int'(spi_cs_n), 1);
    bus(1, 1, 1, 0, 32'h0000_00C5, rd, wt);
    bus(0, 0, 0, 8'h00, 0, rd, wt);
    chk(s_rx == 8'hC5, "R3 cs1 write", s_rx, 8'hC5);
    chk(wt == 17, "R6 code 7 timing", wt, 17);

    // back-to-back writes stall
    bus(1, 1, 1, 0, 32'h0000_003A, rd, wt);
    bus(1, 1, 1, 0, 32'h0000_0096, rd, wt);
    chk(wt == 17, "R9 second write waits", wt, 17);
    bus(0, 0, 0, 8'h00, 0, rd, wt);
    chk(s_rx == 8'h96, "R9 second byte sent", s_rx, 8'h96);

    // write-enable cleared on CS1
    bus(0, 1, 0, 8'h00, 32'h0001_0000, rd, wt);
    r0 = rises;
    bus(1, 1, 1, 0, 32'h0000_0055, rd, wt);
    chk(wt == 0, "R7 disabled write immediate", wt, 0);
    repeat (40) @(negedge clk);
    chk(rises == r0, "R7 disabled write no clock", rises - r0, 0);
    bus(0, 1, 0, 8'h14, ctrl(7, 0, 2'd0), rd, wt);

    // non-user mode on CS0
    bus(0, 1, 0, 8'h10, ctrl(7, 0, 2'd1), rd, wt);
    r0 = rises;
    s_tx = 8'hFF;
    bus(1, 0, 0, 0, 0, rd, wt);
    chk(rd == 0 && wt == 0, "R8 non-user read returns zero at once", rd, 0);
    bus(1, 1, 0, 0, 32'h0000_00AA, rd, wt);
    chk(wt == 0, "R8 non-user write immediate", wt, 0);
    repeat (40) @(negedge clk);
    chk(rises == r0, "R8 non-user no clock", rises - r0, 0);
    chk(spi_cs_n == 2'b11, "R2 both high at end", int'(spi_cs_n), 3);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule